// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block gathers the four interrupt sources of one UART channel, gates each one through a software-written enable register, and reports the most urgent pending source as a code in a read-only identification register. One interrupt request output follows that register. The line status logic, the receive FIFO, the transmit holding register and the modem status logic are not part of this block. They appear only as status inputs.

Software writes the enable register and reads either register through a small strobe-based port. A read access may last several cycles, and while it lasts the identification value does not change. Status changes that arrive during the read are still tracked inside the block. They show up in the identification register on the clock edge after the read strobe drops. The transmitter-empty source is held in a latch. Reading the identification register while it reports that source clears the latch.

Top module: `uart_irq_ident`

## Requirements
- R1: The reported source is chosen by fixed precedence: line status first, then receive data (or timeout), then transmitter empty, then modem status. The codes in identification bits [3:0] are 0110 for line status, 0100 for receive data, 1100 for timeout, 0010 for transmitter empty, 0000 for modem status and 0001 for nothing pending.
- R2: The line status source is pending while enable bit 2 is 1 and any of the four error inputs (overrun, parity, framing, break) is 1.
- R3: With enable bit 0 set, rx_ready yields 0100. When fifo_mode is 1, rx_timeout yields 1100, and this code wins over 0100 if both are present. rx_timeout has no effect while fifo_mode is 0.
- R4: The transmitter-empty source becomes pending when thr_empty rises while enable bit 1 is 1, or when enable bit 1 rises while thr_empty is 1. It clears when thr_empty falls, and also when a read of the identification register that reported 0010 completes.
- R5: The modem status source is pending while enable bit 3 is 1 and dcts is 1.
- R6: A source whose enable bit is 0 is never reported. When all enable bits are 0, the code stays 0001 whatever the inputs are.
- R7: A write to address 0 stores wdata[3:0] into the enable register. A read of address 0 returns those bits, and bits 7:4 read 0.
- R8: The identification register reads 0x01 after reset. Its bits 7:6 both equal fifo_mode and bits 5:4 read 0. A write to address 1 has no effect.
- R9: While reg_rd is held with address 1, the identification value stays constant. Events that occur during the hold appear on the edge after the strobe drops.
- R10: irq is 1 exactly when identification bit 0 is 0. It is driven from registered state, so it changes on the first clock edge after an input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 1 | Register select: 0 enable, 1 identification |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe, held for the whole access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| lsr_err | input | 4 | Overrun, parity, framing, break status |
| rx_ready | input | 1 | Received character available |
| rx_timeout | input | 1 | Character timeout (FIFO mode only) |
| fifo_mode | input | 1 | FIFOs enabled |
| thr_empty | input | 1 | Transmit holding register empty |
| dcts | input | 1 | CTS changed state |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check that the identification value stays constant during a read hold, that enabled line-status errors always produce code 0110, that a fully masked enable register always yields 0001, that the fixed bits of the identification register stay zero, and that irq never rises after a cycle with a read in progress. Only the bench scenarios can show the full precedence ladder under overlapping events. The same holds for the latch behaviour of transmitter empty: arming when the enable bit rises, staying cleared after a read, and dropping when its status falls. The bench also shows that events injected in the middle of a held read appear once the read finishes.

// File: rtl/uirq_pkg.sv
`timescale 1ns/1ps
package uirq_pkg;
    localparam int N_SRC    = 4;
    localparam int ID_W     = 4;
    localparam int SRC_RX   = 0;
    localparam int SRC_THRE = 1;
    localparam int SRC_LSR  = 2;
    localparam int SRC_MSR  = 3;

    typedef enum logic [ID_W-1:0] {
        ID_MODEM  = 4'b0000,
        ID_NONE   = 4'b0001,
        ID_THRE   = 4'b0010,
        ID_RXDATA = 4'b0100,
        ID_LSR    = 4'b0110,
        ID_TMO    = 4'b1100
    } uirq_id_e;

    typedef struct packed {
        logic lsr;
        logic tmo;
        logic rxd;
        logic thre;
        logic msr;
    } uirq_act_t;
endpackage

// File: rtl/uirq_enable_reg.sv
`timescale 1ns/1ps
module uirq_enable_reg
    import uirq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [N_SRC-1:0]  ier
);
    typedef struct packed {
        logic [N_SRC-1:0] ier;
    } st_t;

    st_t s_d, s_q;
    logic unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:N_SRC];

    always_comb begin
        s_d = s_q;
        if (wr_stb) begin
            s_d.ier = wdata[N_SRC-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ier = s_q.ier;
endmodule

// File: rtl/uirq_src_stage.sv
`timescale 1ns/1ps
module uirq_src_stage
    import uirq_pkg::*;
#(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] ier,
    input  logic [ERR_W-1:0] lsr_err,
    input  logic             rx_ready,
    input  logic             rx_timeout,
    input  logic             fifo_mode,
    input  logic             thr_empty,
    input  logic             dcts,
    input  logic             thre_clr,
    output uirq_act_t        act
);
    typedef struct packed {
        logic thre_pend;
        logic thr_prev;
        logic ier_prev;
    } st_t;

    st_t  s_d, s_q;
    logic arm;

    always_comb begin
        s_d          = s_q;
        arm          = (thr_empty & ~s_q.thr_prev) | (ier[SRC_THRE] & ~s_q.ier_prev);
        s_d.thr_prev = thr_empty;
        s_d.ier_prev = ier[SRC_THRE];
        s_d.thre_pend = thr_empty & ier[SRC_THRE] & (arm | (s_q.thre_pend & ~thre_clr));

        act.lsr  = ier[SRC_LSR] & (|lsr_err);
        act.rxd  = ier[SRC_RX] & rx_ready;
        act.tmo  = ier[SRC_RX] & fifo_mode & rx_timeout;
        act.thre = s_d.thre_pend;
        act.msr  = ier[SRC_MSR] & dcts;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/uirq_prio_enc.sv
`timescale 1ns/1ps
module uirq_prio_enc
    import uirq_pkg::*;
(
    input  uirq_act_t       act,
    output logic [ID_W-1:0] code
);
    always_comb begin
        if (act.lsr)       code = ID_LSR;
        else if (act.tmo)  code = ID_TMO;
        else if (act.rxd)  code = ID_RXDATA;
        else if (act.thre) code = ID_THRE;
        else if (act.msr)  code = ID_MODEM;
        else               code = ID_NONE;
    end
endmodule

// File: rtl/uirq_ident_reg.sv
`timescale 1ns/1ps
module uirq_ident_reg
    import uirq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   code,
    input  logic              fifo_mode,
    input  logic              rd_act,
    output logic [DATA_W-1:0] ident,
    output logic              read_done
);
    typedef struct packed {
        logic [DATA_W-1:0] ident;
        logic              rd_prev;
    } st_t;

    st_t               s_d, s_q;
    logic [DATA_W-1:0] fresh;

    always_comb begin
        fresh                 = '0;
        fresh[ID_W-1:0]       = code;
        fresh[DATA_W-1 -: 2]  = {2{fifo_mode}};

        s_d         = s_q;
        s_d.rd_prev = rd_act;
        if (!rd_act) begin
            s_d.ident = fresh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.ident   <= DATA_W'(ID_NONE);
        end else begin
            s_q <= s_d;
        end
    end

    assign ident     = s_q.ident;
    assign read_done = s_q.rd_prev & ~rd_act;
endmodule

// File: rtl/uart_irq_ident.sv
`timescale 1ns/1ps
module uart_irq_ident
    import uirq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ERR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [ERR_W-1:0]  lsr_err,
    input  logic              rx_ready,
    input  logic              rx_timeout,
    input  logic              fifo_mode,
    input  logic              thr_empty,
    input  logic              dcts,
    output logic              irq
);
    localparam logic ADDR_IER = 1'b0;
    localparam logic ADDR_ID  = 1'b1;

    logic [N_SRC-1:0]  ier_w;
    logic [DATA_W-1:0] ident_w;
    logic [ID_W-1:0]   code_w;
    logic              rd_act;
    logic              read_done;
    logic              thre_clr;
    uirq_act_t         act_w;

    assign rd_act   = reg_rd & (reg_addr == ADDR_ID);
    assign thre_clr = read_done & (ident_w[ID_W-1:0] == ID_THRE);

    uirq_enable_reg #(.DATA_W(DATA_W)) u_ier (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (reg_wr & (reg_addr == ADDR_IER)),
        .wdata  (reg_wdata),
        .ier    (ier_w)
    );

    uirq_src_stage #(.ERR_W(ERR_W)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .ier        (ier_w),
        .lsr_err    (lsr_err),
        .rx_ready   (rx_ready),
        .rx_timeout (rx_timeout),
        .fifo_mode  (fifo_mode),
        .thr_empty  (thr_empty),
        .dcts       (dcts),
        .thre_clr   (thre_clr),
        .act        (act_w)
    );

    uirq_prio_enc u_enc (
        .act  (act_w),
        .code (code_w)
    );

    uirq_ident_reg #(.DATA_W(DATA_W)) u_id (
        .clk       (clk),
        .rst_n     (rst_n),
        .code      (code_w),
        .fifo_mode (fifo_mode),
        .rd_act    (rd_act),
        .ident     (ident_w),
        .read_done (read_done)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_IER) reg_rdata[N_SRC-1:0] = ier_w;
        else                      reg_rdata = ident_w;
    end

    assign irq = ~ident_w[0];
endmodule

// File: rtl/uirq_ident_chk.sv
`timescale 1ns/1ps
module uirq_ident_chk #(
    parameter int DATA_W = 8,
    parameter int ERR_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_act,
    input logic              reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [DATA_W-1:0] ident,
    input logic [3:0]        ier,
    input logic [ERR_W-1:0]  lsr_err,
    input logic              irq
);
    // R9: held read keeps the identification value
    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        rd_act |=> $stable(ident));

    // R2: enabled error status always reported as line status
    a_r2_lsr_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_act && ier[2] && (|lsr_err)) |=> (ident[3:0] == 4'b0110));

    // R6: all sources masked gives the idle code
    a_r6_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_act && ier == 4'b0000) |=> (ident[3:0] == 4'b0001));

    // R8: fixed bits stay zero
    a_r8_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ident[DATA_W-3:4] == '0);

    // R7: upper enable bits read zero
    a_r7_ier_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 1'b0) |-> (reg_rdata[DATA_W-1:4] == '0));

    // R10: interrupt cannot rise right after a cycle with a held read
    a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(!rd_act));
endmodule

bind uart_irq_ident uirq_ident_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_act    (rd_act),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .ident     (ident_w),
    .ier       (ier_w),
    .lsr_err   (lsr_err),
    .irq       (irq)
);

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_addr = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [3:0] lsr_err = '0;
    logic       rx_ready = 1'b0;
    logic       rx_timeout = 1'b0;
    logic       fifo_mode = 1'b0;
    logic       thr_empty = 1'b0;
    logic       dcts = 1'b0;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    uart_irq_ident u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lsr_err(lsr_err), .rx_ready(rx_ready), .rx_timeout(rx_timeout),
        .fifo_mode(fifo_mode), .thr_empty(thr_empty), .dcts(dcts), .irq(irq)
    );

    // monitor: compares each read cycle against the scoreboard
    always @(negedge clk) begin
        #2;
        if (reg_rd) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL unexpected read: actual=%h expected=none", reg_rdata);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic push(input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic rd(input logic a, input logic [7:0] e, input string t);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1; push(e, t);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string t);
        total++;
        if (irq !== e) begin
            bad++;
            $display("FAIL %s irq: actual=%b expected=%b", t, irq, e);
        end
    endtask

    task automatic finish_run();
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard: actual=%0d expected=0 leftover", exp_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R8 reset state
        #2 chk_irq(1'b0, "R8 reset");
        rd(1'b1, 8'h01, "R8 reset ident");
        rd(1'b0, 8'h00, "R7 reset enable");

        // R7 enable write, upper bits zero
        wr(1'b0, 8'hFF);
        rd(1'b0, 8'h0F, "R7 enable readback");

        // R4 transmitter empty, cleared by read
        thr_empty = 1'b1;
        step(1);
        #2 chk_irq(1'b1, "R4 thre pending");
        rd(1'b1, 8'h02, "R4 thre code");
        step(1);
        rd(1'b1, 8'h01, "R4 cleared by read");
        thr_empty = 1'b0;

        // R1 simultaneous sources and precedence ladder
        dcts = 1'b1; rx_ready = 1'b1; lsr_err = 4'b0100;
        step(1);
        rd(1'b1, 8'h06, "R1 lsr highest");
        lsr_err = 4'b0000;
        step(1);
        rd(1'b1, 8'h04, "R1 rx data next");
        rx_ready = 1'b0;
        step(1);
        rd(1'b1, 8'h00, "R5 modem status");
        #2 chk_irq(1'b1, "R10 modem irq");
        dcts = 1'b0;
        step(1);
        rd(1'b1, 8'h01, "R1 idle");

        // R2 each error bit alone
        for (int b = 0; b < 4; b++) begin
            lsr_err = 4'b0001 << b;
            step(1);
            rd(1'b1, 8'h06, "R2 error bit");
        end
        lsr_err = '0;

        // R3 timeout and FIFO mode
        fifo_mode = 1'b1; rx_timeout = 1'b1;
        step(1);
        rd(1'b1, 8'hCC, "R3 timeout fifo");
        rx_ready = 1'b1;
        step(1);
        rd(1'b1, 8'hCC, "R3 timeout over data");
        fifo_mode = 1'b0;
        step(1);
        rd(1'b1, 8'h04, "R3 timeout ignored");
        rx_ready = 1'b0;
        step(1);
        rd(1'b1, 8'h01, "R3 idle");
        rx_timeout = 1'b0;

        // R8 write to identification ignored
        wr(1'b1, 8'hFF);
        rd(1'b1, 8'h01, "R8 write ignored");
        rd(1'b0, 8'h0F, "R8 enable untouched");

        // R6 masking
        wr(1'b0, 8'h00);
        lsr_err = 4'b1000; rx_ready = 1'b1; dcts = 1'b1; thr_empty = 1'b1;
        step(1);
        rd(1'b1, 8'h01, "R6 all masked");
        #2 chk_irq(1'b0, "R6 masked irq");
        wr(1'b0, 8'h08);
        step(1);
        rd(1'b1, 8'h00, "R6 only modem enabled");

        // R4 enable rise arms while empty, status fall clears
        lsr_err = '0; rx_ready = 1'b0; dcts = 1'b0;
        wr(1'b0, 8'h02);
        step(1);
        rd(1'b1, 8'h02, "R4 enable rise arms");
        thr_empty = 1'b0;
        step(1);
        rd(1'b1, 8'h01, "R4 status fall clears");

        // R10 one-clock timing of irq
        wr(1'b0, 8'h0F);
        step(1);
        dcts = 1'b1;
        #2 chk_irq(1'b0, "R10 before edge");
        @(posedge clk); #2 chk_irq(1'b1, "R10 after edge");
        @(negedge clk);
        dcts = 1'b0;
        step(2);

        // R9 freeze during held read
        reg_addr = 1'b1; reg_rd = 1'b1; push(8'h01, "R9 hold c0");
        @(negedge clk); push(8'h01, "R9 hold c1");
        lsr_err = 4'b0001;
        @(negedge clk); push(8'h01, "R9 hold c2");
        #2 chk_irq(1'b0, "R9 irq frozen");
        @(negedge clk); push(8'h01, "R9 hold c3");
        @(negedge clk); reg_rd = 1'b0;
        rd(1'b1, 8'h06, "R9 event after release");
        lsr_err = '0;
        step(2);

        done = 1'b1;
        finish_run();
    end
endmodule